// File: doc/BRIEF.md
# Two-Pipe Banked Data Array Access Arbiter

This block sits in front of a single-ported data array built from eight 32-bit banks, with consecutive words placed in consecutive banks. Each clock it takes up to two memory references, one from pipe U and one from pipe V. It works out which banks each reference touches and decides which references may proceed. A 32-bit reference needs one bank. A 64-bit reference needs an aligned pair of banks, which together form a 64-bit path.

When the two references share no bank, both are granted in the same clock. When they share a bank, U goes first and V stalls for one clock. Two references to the same word always share a bank, so they are always serialised, and no separate data-dependency check is needed. A V reference that was stalled, and still requests, has priority in the next clock. U joins it in that clock only if the two are disjoint.

Conflict resolution is combinational within the request cycle. The grants, stall, error flags, per-bank enables and per-bank pipe selects are registered, so the bank accesses take place in the following pipeline stage.

Top module: `dpbank_arb`

## Requirements
- R1: A 32-bit reference uses exactly one bank, whose index is address bits [4:2].
- R2: When both pipes make valid references that share no bank, both grants are asserted in the same output cycle. The bank enables are then the union of both references' banks.
- R3: When valid U and V references share a bank and V does not hold priority, U is granted, V is not granted, and v_stall is asserted.
- R4: Two references to the same word address are treated as a bank conflict under R3.
- R5: A 64-bit reference (wide=1) with address bit 2 clear enables banks 2k and 2k+1 together, where k is address bits [4:3].
- R6: A 64-bit reference with address bit 2 set raises that pipe's error flag, is not granted, and enables no bank.
- R7: A V reference stalled in one cycle that still requests in the next is granted in the next, without a stall. U is granted alongside it only if the two are disjoint. v_stall is never asserted in two consecutive cycles.
- R8: A valid V reference with no U request is granted with no stall.
- R9: During and right after reset, all grants, flags, enables and selects are 0.
- R10: Outputs reflect the requests of the previous clock edge. A bank's select bit is 1 when V drives it and 0 otherwise. A disabled bank always has select 0.
- R11: With no request, or only rejected requests, all banks stay disabled and no grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| u_req | input | 1 | Pipe U reference valid |
| u_wide | input | 1 | Pipe U reference is 64-bit |
| u_addr | input | 32 | Pipe U byte address |
| v_req | input | 1 | Pipe V reference valid |
| v_wide | input | 1 | Pipe V reference is 64-bit |
| v_addr | input | 32 | Pipe V byte address |
| bank_en | output | 8 | Per-bank access enable (registered) |
| bank_sel | output | 8 | Per-bank source: 1 = pipe V, 0 = pipe U |
| u_grant | output | 1 | Pipe U reference accepted |
| v_grant | output | 1 | Pipe V reference accepted |
| v_stall | output | 1 | Pipe V held back by a bank conflict |
| u_err | output | 1 | Pipe U misaligned 64-bit reference |
| v_err | output | 1 | Pipe V misaligned 64-bit reference |

## Verification
The hardest situation to reach is the recovery cycle after a stall, where V holds priority. Only there can U lose to V, and only there does the outcome depend on the previous cycle as well as the current inputs. The stimulus first forces a conflict. In the very next cycle it keeps V's request and presents a fresh U reference, once disjoint from V and once overlapping it. This checks both that U joins V and that U is refused, and also that the stall is not repeated.

// File: rtl/dpbank_arb_pkg.sv
package dpbank_arb_pkg;
  localparam int ADDR_W     = 32;
  localparam int NBANK      = 8;
  localparam int BANK_BITS  = 32;
  localparam int BANK_BYTES = BANK_BITS / 8;
  localparam int OFS_W      = $clog2(BANK_BYTES);
  localparam int IDX_W      = $clog2(NBANK);

  typedef logic [NBANK-1:0]  bmask_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic { SRC_U = 1'b0, SRC_V = 1'b1 } src_e;

  typedef struct packed {
    logic   ok;
    logic   err;
    bmask_t mask;
  } ref_t;

  function automatic logic [IDX_W-1:0] bank_index(addr_t a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic wide_misaligned(addr_t a, logic wide);
    return wide && a[OFS_W];
  endfunction

  function automatic bmask_t bank_need(addr_t a, logic wide);
    bmask_t           m;
    logic [IDX_W-1:0] idx;
    m   = '0;
    idx = bank_index(a);
    if (wide) begin
      m[{idx[IDX_W-1:1], 1'b0}] = 1'b1;
      m[{idx[IDX_W-1:1], 1'b1}] = 1'b1;
    end else begin
      m[idx] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dpbank_arb_decode.sv
module dpbank_arb_decode
  import dpbank_arb_pkg::*;
(
  input  logic  req,
  input  logic  wide,
  input  addr_t addr,
  output ref_t  rf
);
  logic bad;
  assign bad     = wide_misaligned(addr, wide);
  assign rf.ok   = req && !bad;
  assign rf.err  = req && bad;
  assign rf.mask = rf.ok ? bank_need(addr, wide) : '0;

  always_comb begin
    if (rf.ok && wide)
      p_wide_pair_r5: assert ($countones(rf.mask) == 2);
    if (rf.ok && !wide)
      p_narrow_one_r1: assert ($countones(rf.mask) == 1);
    if (!rf.ok)
      p_idle_none_r11: assert (rf.mask == '0);
  end
endmodule

// File: rtl/dpbank_arb_resolve.sv
module dpbank_arb_resolve
  import dpbank_arb_pkg::*;
(
  input  ref_t u_ref,
  input  ref_t v_ref,
  input  logic v_prio,
  output logic u_go,
  output logic v_go,
  output logic v_block,
  output logic overlap
);
  assign overlap = |(u_ref.mask & v_ref.mask);

  always_comb begin
    u_go    = 1'b0;
    v_go    = 1'b0;
    v_block = 1'b0;
    if (v_prio) begin
      v_go = v_ref.ok;
      u_go = u_ref.ok && !(v_ref.ok && overlap);
    end else begin
      u_go    = u_ref.ok;
      v_go    = v_ref.ok && !(u_ref.ok && overlap);
      v_block = v_ref.ok && u_ref.ok && overlap;
    end
  end

  always_comb begin
    p_no_double_r2: assert (!(u_go && v_go && overlap));
    if (v_block)
      p_block_u_wins_r3: assert (u_go && !v_go);
  end
endmodule

// File: rtl/dpbank_arb_route.sv
module dpbank_arb_route
  import dpbank_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  bmask_t u_mask,
  input  bmask_t v_mask,
  input  logic   u_go,
  input  logic   v_go,
  input  logic   v_block,
  input  logic   u_bad,
  input  logic   v_bad,
  output bmask_t bank_en,
  output bmask_t bank_sel,
  output logic   u_grant,
  output logic   v_grant,
  output logic   v_stall,
  output logic   u_err,
  output logic   v_err
);
  bmask_t en_d, sel_d;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic u_hit, v_hit;
    assign u_hit    = u_go && u_mask[b];
    assign v_hit    = v_go && v_mask[b];
    assign en_d[b]  = u_hit || v_hit;
    assign sel_d[b] = v_hit ? SRC_V : SRC_U;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_en[b]  <= 1'b0;
        bank_sel[b] <= 1'b0;
      end else begin
        bank_en[b]  <= en_d[b];
        bank_sel[b] <= sel_d[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_grant <= 1'b0;
      v_grant <= 1'b0;
      v_stall <= 1'b0;
      u_err   <= 1'b0;
      v_err   <= 1'b0;
    end else begin
      u_grant <= u_go;
      v_grant <= v_go;
      v_stall <= v_block;
      u_err   <= u_bad;
      v_err   <= v_bad;
    end
  end

  p_sel_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel & ~bank_en) == '0);
  p_grant_has_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (u_grant || v_grant) |-> (bank_en != '0));
endmodule

// File: rtl/dpbank_arb.sv
module dpbank_arb
  import dpbank_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              u_req,
  input  logic              u_wide,
  input  logic [ADDR_W-1:0] u_addr,
  input  logic              v_req,
  input  logic              v_wide,
  input  logic [ADDR_W-1:0] v_addr,
  output logic [NBANK-1:0]  bank_en,
  output logic [NBANK-1:0]  bank_sel,
  output logic              u_grant,
  output logic              v_grant,
  output logic              v_stall,
  output logic              u_err,
  output logic              v_err
);
  ref_t u_ref, v_ref;
  logic u_go, v_go, v_block, overlap;
  logic v_prio_q;

  dpbank_arb_decode i_dec_u (.req(u_req), .wide(u_wide), .addr(u_addr), .rf(u_ref));
  dpbank_arb_decode i_dec_v (.req(v_req), .wide(v_wide), .addr(v_addr), .rf(v_ref));

  dpbank_arb_resolve i_resolve (
    .u_ref(u_ref), .v_ref(v_ref), .v_prio(v_prio_q),
    .u_go(u_go), .v_go(v_go), .v_block(v_block), .overlap(overlap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) v_prio_q <= 1'b0;
    else        v_prio_q <= v_block;
  end

  dpbank_arb_route i_route (
    .clk(clk), .rst_n(rst_n),
    .u_mask(u_ref.mask), .v_mask(v_ref.mask),
    .u_go(u_go), .v_go(v_go), .v_block(v_block),
    .u_bad(u_ref.err), .v_bad(v_ref.err),
    .bank_en(bank_en), .bank_sel(bank_sel),
    .u_grant(u_grant), .v_grant(v_grant), .v_stall(v_stall),
    .u_err(u_err), .v_err(v_err)
  );

  p_stall_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    v_stall |=> !v_stall);
  p_stall_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v_stall |-> (u_grant && !v_grant));
  p_held_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_prio_q && v_ref.ok) |=> v_grant);
  p_only_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ref.ok && !u_req) |=> (v_grant && !v_stall));
  p_err_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(u_err && u_grant) && !(v_err && v_grant));
endmodule

// File: tb/test_dpbank_arb.sv
module test_dpbank_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        u_req = 1'b0, u_wide = 1'b0, v_req = 1'b0, v_wide = 1'b0;
  logic [31:0] u_addr = '0, v_addr = '0;
  logic [7:0]  bank_en, bank_sel;
  logic        u_grant, v_grant, v_stall, u_err, v_err;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dpbank_arb i_dpbank_arb (
    .clk(clk), .rst_n(rst_n),
    .u_req(u_req), .u_wide(u_wide), .u_addr(u_addr),
    .v_req(v_req), .v_wide(v_wide), .v_addr(v_addr),
    .bank_en(bank_en), .bank_sel(bank_sel),
    .u_grant(u_grant), .v_grant(v_grant), .v_stall(v_stall),
    .u_err(u_err), .v_err(v_err)
  );

  // Expected bank set, restated arithmetically.
  function automatic logic [7:0] need(logic [31:0] a, logic w);
    int i;
    i = int'((a >> 2) & 32'd7);
    if (w) return 8'(3 << (i & 6));
    return 8'(1 << i);
  endfunction

  task automatic chk(string tag, logic ug, logic vg, logic vs, logic ue, logic ve,
                     logic [7:0] en, logic [7:0] sel);
    logic [20:0] got, exp;
    got = {u_grant, v_grant, v_stall, u_err, v_err, bank_en, bank_sel};
    exp = {ug, vg, vs, ue, ve, en, sel};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got ug%b vg%b vs%b ue%b ve%b en=%h sel=%h exp ug%b vg%b vs%b ue%b ve%b en=%h sel=%h",
               tag, got[20], got[19], got[18], got[17], got[16], got[15:8], got[7:0],
               ug, vg, vs, ue, ve, en, sel);
    end
  endtask

  task automatic drive(logic ur, logic [31:0] ua, logic uw, logic vr, logic [31:0] va, logic vw);
    u_req = ur; u_addr = ua; u_wide = uw;
    v_req = vr; v_addr = va; v_wide = vw;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    drive(0, 0, 0, 0, 0, 0);
    step();
  endtask

  task automatic t_reset;
    drive(1, 32'h0, 0, 1, 32'h4, 0);
    step();
    chk("R9 in reset", 0, 0, 0, 0, 0, 8'h00, 8'h00);
    drive(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    step();
    chk("R9 after reset", 0, 0, 0, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic t_single_u;
    for (int b = 0; b < 8; b++) begin
      logic [31:0] a;
      a = 32'h1000 + 32'(b * 4) + 32'(b % 4);
      drive(1, a, 0, 0, 0, 0);
      step();
      chk("R1 single U bank", 1, 0, 0, 0, 0, need(a, 0), 8'h00);
    end
    idle();
  endtask

  task automatic t_disjoint;
    drive(1, 32'h20, 0, 1, 32'h3C, 0);
    step();
    chk("R2 disjoint narrow", 1, 1, 0, 0, 0, 8'h81, 8'h80);
    drive(1, 32'h48, 1, 1, 32'h50, 1);
    step();
    chk("R2 disjoint wide", 1, 1, 0, 0, 0, 8'h3C, 8'h30);
    idle();
  endtask

  task automatic t_conflict;
    drive(1, 32'h08, 0, 1, 32'h28, 0);
    step();
    chk("R3 conflict U wins", 1, 0, 1, 0, 0, 8'h04, 8'h00);
    idle();
    chk("R7 dropped V no grant", 0, 0, 0, 0, 0, 8'h00, 8'h00);
    drive(1, 32'h10, 1, 1, 32'h14, 0);
    step();
    chk("R3 wide vs narrow conflict", 1, 0, 1, 0, 0, 8'h30, 8'h00);
    idle();
  endtask

  task automatic t_same_addr;
    drive(1, 32'h74, 0, 1, 32'h74, 0);
    step();
    chk("R4 same word", 1, 0, 1, 0, 0, 8'h20, 8'h00);
    drive(0, 0, 0, 1, 32'h74, 0);
    step();
    chk("R4 second access", 0, 1, 0, 0, 0, 8'h20, 8'h20);
    idle();
  endtask

  task automatic t_wide;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = 32'h200 + 32'(k * 8);
      drive(0, 0, 0, 1, a, 1);
      step();
      chk("R5 wide pair V", 0, 1, 0, 0, 0, 8'(3 << (2 * k)), 8'(3 << (2 * k)));
    end
    idle();
  endtask

  task automatic t_misaligned;
    drive(1, 32'h0C, 1, 0, 0, 0);
    step();
    chk("R6 U misaligned", 0, 0, 0, 1, 0, 8'h00, 8'h00);
    drive(1, 32'h0C, 0, 1, 32'h0C, 1);
    step();
    chk("R6 V misaligned no conflict", 1, 0, 0, 0, 1, 8'h08, 8'h00);
    drive(1, 32'h04, 1, 1, 32'h14, 1);
    step();
    chk("R11 both rejected", 0, 0, 0, 1, 1, 8'h00, 8'h00);
    idle();
  endtask

  task automatic t_recover;
    drive(1, 32'h00, 0, 1, 32'h00, 1);
    step();
    chk("R3 stall before recovery", 1, 0, 1, 0, 0, 8'h01, 8'h00);
    drive(1, 32'h18, 0, 1, 32'h00, 1);
    step();
    chk("R7 V and disjoint U", 1, 1, 0, 0, 0, 8'h43, 8'h03);
    drive(1, 32'h30, 0, 1, 32'h10, 0);
    step();
    chk("R3 stall again", 1, 0, 1, 0, 0, 8'h10, 8'h00);
    drive(1, 32'h90, 0, 1, 32'h10, 0);
    step();
    chk("R7 V wins overlap", 0, 1, 0, 0, 0, 8'h10, 8'h10);
    drive(1, 32'h90, 0, 1, 32'h10, 0);
    step();
    chk("R7 priority returns to U", 1, 0, 1, 0, 0, 8'h10, 8'h00);
    idle();
  endtask

  task automatic t_v_only;
    drive(0, 0, 0, 1, 32'h1C, 0);
    step();
    chk("R8 V only", 0, 1, 0, 0, 0, 8'h80, 8'h80);
    idle();
    chk("R11 idle", 0, 0, 0, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic t_latency;
    drive(1, 32'h04, 0, 0, 0, 0);
    #1;
    chk("R10 no change before edge", 0, 0, 0, 0, 0, 8'h00, 8'h00);
    step();
    chk("R10 after edge", 1, 0, 0, 0, 0, 8'h02, 8'h00);
    idle();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single_u();
    t_disjoint();
    t_conflict();
    t_same_addr();
    t_wide();
    t_misaligned();
    t_recover();
    t_v_only();
    t_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule